// File: doc/BRIEF.md
# Nearest-Neighbor Video Scaler

This block takes a video stream of one pixel per beat, with a start-of-frame flag on the first pixel, and resizes every frame to an output width and height held in software-writable registers. Each output pixel is a plain copy of one input pixel. No filtering is applied. The column of the source pixel comes from a 16.16 fixed-point accumulator that advances by a horizontal step. The row of the source line comes from a second accumulator that advances by its own vertical step. The two ratios are independent, so a frame can shrink in one direction and grow in the other.

The block keeps one input line in a local buffer. After the line has been captured, the block emits every output row whose source is that line. It then fetches the next line. If the frame grows vertically, the same stored line is replayed, and the input is stalled while that happens. If the frame shrinks vertically, lines that no output row needs are captured and then skipped. A build parameter can turn off scaling in either direction. The output size in that direction then follows the input size.

The block checks the programmed sizes and the chroma format code on each start-of-frame beat. Any violation sets a sticky error flag and the frame is dropped. Every frame that arrives while the flag is set is also dropped, until software clears the flag.

Top module: `nn_scaler`

## Requirements
- R1: Register map, addressed through `reg_addr`:
  - 0 is the output width.
  - 1 is the output height.
  - 2 is the input width.
  - 3 is the input height.
  - 4 is status: bit 0 is busy, bit 1 is the error flag.
  - Size registers are 16 bits, read back what was written, and reset to 16, 8, 16 and 8.
  - Status reads 0 after reset.
- R2: Within an output line, output pixel i copies input column floor(i*Sh/65536), where Sh = floor(in_w*65536/out_w).
- R3: Output row j is taken from input row floor(j*Sv/65536), where Sv = floor(in_h*65536/out_h).
- R4: The horizontal and vertical ratios are independent. A frame is emitted as out_h lines of out_w beats. `out_sof` marks only the first beat of the frame, and `out_eol` marks only the last beat of each line.
- R5: Sizes are sampled on the accepted start-of-frame beat. A register write made later in the same frame does not change that frame, and it reads back at once.
- R6: With a direction's scaling turned off by parameter, that output dimension equals the input dimension and the pixels pass through unchanged, whatever the output registers hold.
- R7: On a start-of-frame beat, the error flag is set and the frame produces no output if any of the following holds:
  - input width is 0 or greater than MAX_IN_W;
  - input height is 0;
  - effective output width is below MIN_OUT_W or above MAX_OUT_W;
  - effective output height is 0;
  - `in_fmt` is not 0, where 0 is the only accepted code and means 4:4:4.
- R8: The error flag is sticky. Writing 1 to status bit 1 clears it. Writing 0 to that bit leaves it set.
- R9: While the error flag is set, `in_ready` stays high, all input is discarded and no output beat appears.
- R10: `in_ready` is low only while the block is busy, which is the case when a stored line is being emitted. Busy is set from an accepted start-of-frame beat until the last output line has left. When idle, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with `in_valid` |
| in_sof | input | 1 | First pixel of an input frame |
| in_fmt | input | 2 | Chroma format code sampled with `in_sof` (0 = 4:4:4) |
| in_data | input | DW | Input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | First pixel of an output frame |
| out_eol | output | 1 | Last pixel of an output line |
| out_data | output | DW | Output pixel |

## Verification
Each output beat is registered. It appears one cycle after the emit step that chose it, and the first beat of a line follows the last input beat of its source line by two cycles. The error flag shows in status one cycle after the offending start-of-frame beat, and the status read path is combinational. Because the timing of output beats depends on the size ratios, the bench does not pin beats to cycles. It records every valid beat at the falling edge, waits until status reports idle, and then compares the recorded stream in order against the stream computed from the sizes. Register and flag checks are read at the falling edge, after the edge that updates them.

// File: rtl/nn_scaler_pkg.sv
`timescale 1ns/1ps
package nn_scaler_pkg;
    localparam int FRAC = 16;
    localparam int SW   = 16;

    localparam logic [2:0] ADDR_OUT_W  = 3'd0;
    localparam logic [2:0] ADDR_OUT_H  = 3'd1;
    localparam logic [2:0] ADDR_IN_W   = 3'd2;
    localparam logic [2:0] ADDR_IN_H   = 3'd3;
    localparam logic [2:0] ADDR_STATUS = 3'd4;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_ERR_BIT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_EMIT    = 2'd2
    } nn_state_e;
endpackage

// File: rtl/nn_step_calc.sv
`timescale 1ns/1ps
module nn_step_calc #(
    parameter bit ENABLE = 1'b1,
    parameter int SW     = 16,
    parameter int FRAC   = 16
) (
    input  logic [SW-1:0]      in_size,
    input  logic [SW-1:0]      req_size,
    output logic [SW-1:0]      eff_size,
    output logic [SW+FRAC-1:0] step
);
    localparam int ACC_W = SW + FRAC;
    localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC;

    generate
        if (ENABLE) begin : g_scale
            logic [ACC_W-1:0] num;
            logic [ACC_W-1:0] den;
            assign num      = {in_size, {FRAC{1'b0}}};
            assign den      = {{FRAC{1'b0}}, req_size};
            assign eff_size = req_size;
            assign step     = (req_size == '0) ? '0 : num / den;
        end else begin : g_bypass
            logic unused_req;
            assign unused_req = ^req_size;
            assign eff_size   = in_size;
            assign step       = UNIT;
        end
    endgenerate
endmodule

// File: rtl/nn_size_check.sv
`timescale 1ns/1ps
module nn_size_check #(
    parameter int SW        = 16,
    parameter int MAX_IN_W  = 64,
    parameter int MAX_OUT_W = 128,
    parameter int MIN_OUT_W = 1
) (
    input  logic [SW-1:0] in_w,
    input  logic [SW-1:0] in_h,
    input  logic [SW-1:0] out_w,
    input  logic [SW-1:0] out_h,
    input  logic [1:0]    fmt,
    output logic          bad
);
    always_comb begin
        bad = 1'b0;
        if (in_w == '0 || int'(in_w) > MAX_IN_W)                bad = 1'b1;
        if (in_h == '0)                                          bad = 1'b1;
        if (int'(out_w) < MIN_OUT_W || int'(out_w) > MAX_OUT_W) bad = 1'b1;
        if (out_w == '0 || out_h == '0)                          bad = 1'b1;
        if (fmt != 2'd0)                                         bad = 1'b1;
    end
endmodule

// File: rtl/nn_line_buf.sv
`timescale 1ns/1ps
module nn_line_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nn_scaler.sv
`timescale 1ns/1ps
module nn_scaler
    import nn_scaler_pkg::*;
#(
    parameter int DW         = 16,
    parameter int MAX_IN_W   = 64,
    parameter int MAX_OUT_W  = 128,
    parameter int MIN_OUT_W  = 1,
    parameter bit H_SCALE_EN = 1'b1,
    parameter bit V_SCALE_EN = 1'b1,
    parameter int RST_OUT_W  = 16,
    parameter int RST_OUT_H  = 8,
    parameter int RST_IN_W   = 16,
    parameter int RST_IN_H   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_sof,
    input  logic [1:0]    in_fmt,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_eol,
    output logic [DW-1:0] out_data
);
    localparam int AW    = $clog2(MAX_IN_W);
    localparam int ACC_W = SW + FRAC;

    typedef struct packed {
        nn_state_e        st;
        logic             err;
        logic [SW-1:0]    cfg_ow, cfg_oh, cfg_iw, cfg_ih;
        logic [SW-1:0]    act_iw, act_ih, act_ow, act_oh;
        logic [ACC_W-1:0] hstep, vstep, hacc, vacc;
        logic [SW-1:0]    col, cap_row, out_row, ocol;
        logic             ov, osof, oeol;
        logic [DW-1:0]    odata;
    } regs_t;

    regs_t r_q, r_d;

    logic [SW-1:0]    eff_ow, eff_oh;
    logic [ACC_W-1:0] hstep_w, vstep_w;
    logic             size_bad;
    logic             buf_we;
    logic [AW-1:0]    buf_wa;
    logic [DW-1:0]    buf_rd;
    logic             busy_w, err_w;
    logic             emit_now;

    nn_step_calc #(.ENABLE(H_SCALE_EN), .SW(SW), .FRAC(FRAC)) u_hstep (
        .in_size(r_q.cfg_iw), .req_size(r_q.cfg_ow), .eff_size(eff_ow), .step(hstep_w)
    );
    nn_step_calc #(.ENABLE(V_SCALE_EN), .SW(SW), .FRAC(FRAC)) u_vstep (
        .in_size(r_q.cfg_ih), .req_size(r_q.cfg_oh), .eff_size(eff_oh), .step(vstep_w)
    );
    nn_size_check #(.SW(SW), .MAX_IN_W(MAX_IN_W), .MAX_OUT_W(MAX_OUT_W),
                    .MIN_OUT_W(MIN_OUT_W)) u_chk_size (
        .in_w(r_q.cfg_iw), .in_h(r_q.cfg_ih), .out_w(eff_ow), .out_h(eff_oh),
        .fmt(in_fmt), .bad(size_bad)
    );
    nn_line_buf #(.DW(DW), .DEPTH(MAX_IN_W)) u_line (
        .clk(clk), .wr_en(buf_we), .wr_addr(buf_wa), .wr_data(in_data),
        .rd_addr(r_q.hacc[FRAC +: AW]), .rd_data(buf_rd)
    );

    assign emit_now = (r_q.out_row < r_q.act_oh) && (r_q.vacc[ACC_W-1:FRAC] == r_q.cap_row);

    always_comb begin
        r_d        = r_q;
        r_d.ov     = 1'b0;
        r_d.osof   = 1'b0;
        r_d.oeol   = 1'b0;
        buf_we     = 1'b0;
        buf_wa     = r_q.col[AW-1:0];

        if (reg_we) begin
            case (reg_addr)
                ADDR_OUT_W:  r_d.cfg_ow = reg_wdata;
                ADDR_OUT_H:  r_d.cfg_oh = reg_wdata;
                ADDR_IN_W:   r_d.cfg_iw = reg_wdata;
                ADDR_IN_H:   r_d.cfg_ih = reg_wdata;
                ADDR_STATUS: if (reg_wdata[STAT_ERR_BIT]) r_d.err = 1'b0;
                default: ;
            endcase
        end

        case (r_q.st)
            ST_IDLE: begin
                if (in_valid && in_sof && !r_q.err) begin
                    if (size_bad) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.act_iw  = r_q.cfg_iw;
                        r_d.act_ih  = r_q.cfg_ih;
                        r_d.act_ow  = eff_ow;
                        r_d.act_oh  = eff_oh;
                        r_d.hstep   = hstep_w;
                        r_d.vstep   = vstep_w;
                        r_d.hacc    = '0;
                        r_d.vacc    = '0;
                        r_d.cap_row = '0;
                        r_d.out_row = '0;
                        r_d.ocol    = '0;
                        buf_we      = 1'b1;
                        buf_wa      = '0;
                        if (r_q.cfg_iw == SW'(1)) begin
                            r_d.col = '0;
                            r_d.st  = ST_EMIT;
                        end else begin
                            r_d.col = SW'(1);
                            r_d.st  = ST_CAPTURE;
                        end
                    end
                end
            end
            ST_CAPTURE: begin
                if (in_valid) begin
                    buf_we = 1'b1;
                    if (r_q.col == r_q.act_iw - SW'(1)) begin
                        r_d.col = '0;
                        r_d.st  = ST_EMIT;
                    end else begin
                        r_d.col = r_q.col + SW'(1);
                    end
                end
            end
            ST_EMIT: begin
                if (emit_now) begin
                    r_d.ov    = 1'b1;
                    r_d.odata = buf_rd;
                    r_d.osof  = (r_q.out_row == '0) && (r_q.ocol == '0);
                    r_d.oeol  = (r_q.ocol == r_q.act_ow - SW'(1));
                    if (r_q.ocol == r_q.act_ow - SW'(1)) begin
                        r_d.ocol    = '0;
                        r_d.hacc    = '0;
                        r_d.out_row = r_q.out_row + SW'(1);
                        r_d.vacc    = r_q.vacc + r_q.vstep;
                    end else begin
                        r_d.ocol = r_q.ocol + SW'(1);
                        r_d.hacc = r_q.hacc + r_q.hstep;
                    end
                end else if (r_q.cap_row == r_q.act_ih - SW'(1)) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cap_row = r_q.cap_row + SW'(1);
                    r_d.st      = ST_CAPTURE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.cfg_ow <= SW'(RST_OUT_W);
            r_q.cfg_oh <= SW'(RST_OUT_H);
            r_q.cfg_iw <= SW'(RST_IN_W);
            r_q.cfg_ih <= SW'(RST_IN_H);
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_w    = (r_q.st != ST_IDLE);
    assign err_w     = r_q.err;
    assign in_ready  = (r_q.st != ST_EMIT);
    assign out_valid = r_q.ov;
    assign out_sof   = r_q.osof;
    assign out_eol   = r_q.oeol;
    assign out_data  = r_q.odata;

    always_comb begin
        case (reg_addr)
            ADDR_OUT_W:  reg_rdata = r_q.cfg_ow;
            ADDR_OUT_H:  reg_rdata = r_q.cfg_oh;
            ADDR_IN_W:   reg_rdata = r_q.cfg_iw;
            ADDR_IN_H:   reg_rdata = r_q.cfg_ih;
            ADDR_STATUS: reg_rdata = {14'd0, err_w, busy_w};
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nn_scaler_chk.sv
`timescale 1ns/1ps
module nn_scaler_chk
    import nn_scaler_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        in_valid,
    input logic        in_sof,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_sof,
    input logic        out_eol,
    input logic        busy,
    input logic        err
);
    logic clr_wr;
    assign clr_wr = reg_we && (reg_addr == ADDR_STATUS) && reg_wdata[STAT_ERR_BIT];

    // R10
    ready_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> busy);

    // R9
    no_out_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid);

    // R4
    sof_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R4
    eol_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_valid);

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !(in_valid && in_sof)) |=> !err);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_wr) |=> err);

    // R10
    out_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));
endmodule

bind nn_scaler nn_scaler_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_sof(in_sof),
    .in_ready(in_ready), .out_valid(out_valid), .out_sof(out_sof),
    .out_eol(out_eol), .busy(busy_w), .err(err_w)
);

// File: tb/nn_scaler_tb.sv
`timescale 1ns/1ps
module nn_scaler_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [1:0]  in_fmt = 2'd0;
    logic [15:0] in_data = '0;

    logic [15:0] a_rdata, b_rdata, a_data, b_data;
    logic a_ready, b_ready, a_valid, b_valid, a_sof, b_sof, a_eol, b_eol;

    nn_scaler u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we && !sel), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(a_rdata), .in_valid(in_valid && !sel),
        .in_ready(a_ready), .in_sof(in_sof), .in_fmt(in_fmt), .in_data(in_data),
        .out_valid(a_valid), .out_sof(a_sof), .out_eol(a_eol), .out_data(a_data)
    );
    nn_scaler #(.H_SCALE_EN(1'b0), .V_SCALE_EN(1'b0)) u_byp (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we && sel), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(b_rdata), .in_valid(in_valid && sel),
        .in_ready(b_ready), .in_sof(in_sof), .in_fmt(in_fmt), .in_data(in_data),
        .out_valid(b_valid), .out_sof(b_sof), .out_eol(b_eol), .out_data(b_data)
    );

    wire        m_ready = sel ? b_ready : a_ready;
    wire [15:0] m_rdata = sel ? b_rdata : a_rdata;
    wire        m_valid = sel ? b_valid : a_valid;
    wire        m_sof   = sel ? b_sof : a_sof;
    wire        m_eol   = sel ? b_eol : a_eol;
    wire [15:0] m_data  = sel ? b_data : a_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [17:0] got_q[$];

    always @(negedge clk) if (m_valid) got_q.push_back({m_sof, m_eol, m_data});

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d[15:0];
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(m_rdata);
    endtask

    task automatic send_frame(input int iw, input int ih, input int fmt, input int mid_w);
        for (int r = 0; r < ih; r++) begin
            for (int c = 0; c < iw; c++) begin
                @(negedge clk);
                reg_we   = 1'b0;
                in_valid = 1'b1;
                in_sof   = (r == 0 && c == 0);
                in_fmt   = fmt[1:0];
                in_data  = {r[7:0], c[7:0]};
                if (mid_w > 0 && r == 0 && c == 1) begin
                    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = mid_w[15:0];
                end
                #1;
                while (!m_ready) begin
                    @(negedge clk);
                    reg_we = 1'b0;
                    #1;
                end
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int s;
        int n;
        s = 1; n = 0;
        while ((s & 1) != 0 && n < 20000) begin
            rd(3'd4, s);
            n++;
        end
        chk({req, " busy clears after frame"}, s & 1, 0);
    endtask

    // Sizes are programmed, one frame is sent, and the recorded stream is
    // compared with the stream computed from R2/R3/R4/R6.
    task automatic run_frame(input string req, input int iw, input int ih,
                             input int ow, input int oh, input int fmt,
                             input int mid_w, input bit hen, input bit ven,
                             input bit drop);
        longint hs, vs;
        int eow, eoh, n, mism, k;
        logic [17:0] exp_b;
        wr(3'd0, ow); wr(3'd1, oh); wr(3'd2, iw); wr(3'd3, ih);
        got_q.delete();
        send_frame(iw, ih, fmt, mid_w);
        wait_idle(req);
        @(negedge clk);
        eow = hen ? ow : iw;
        eoh = ven ? oh : ih;
        hs  = hen ? ((longint'(iw) << 16) / ow) : 65536;
        vs  = ven ? ((longint'(ih) << 16) / oh) : 65536;
        n   = drop ? 0 : eow * eoh;
        chk({req, " beat count"}, got_q.size(), n);
        mism = 0; k = 0;
        if (!drop && got_q.size() == n) begin
            for (int j = 0; j < eoh; j++) begin
                for (int i = 0; i < eow; i++) begin
                    longint sr, sc;
                    sr = (j * vs) >>> 16;
                    sc = (i * hs) >>> 16;
                    exp_b = {(i == 0 && j == 0), (i == eow - 1), sr[7:0], sc[7:0]};
                    if (got_q[k] !== exp_b) begin
                        if (mism == 0)
                            $display("FAIL %s: beat %0d actual %h expected %h", req, k, got_q[k], exp_b);
                        mism++;
                    end
                    k++;
                end
            end
        end
        n_chk++;
        if (mism != 0) n_err++;
    endtask

    task automatic clear_err;
        int s;
        wr(3'd4, 2);
        rd(3'd4, s);
        chk("R8 error cleared by writing 1", (s >> 1) & 1, 0);
    endtask

    task automatic expect_err(input string req);
        int s;
        rd(3'd4, s);
        chk({req, " error flag set"}, (s >> 1) & 1, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int s;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R10 idle ready
        rd(3'd0, s); chk("R1 reset out_w", s, 16);
        rd(3'd1, s); chk("R1 reset out_h", s, 8);
        rd(3'd2, s); chk("R1 reset in_w", s, 16);
        rd(3'd3, s); chk("R1 reset in_h", s, 8);
        rd(3'd4, s); chk("R1 reset status", s, 0);
        chk("R10 ready when idle", m_ready, 1);
        chk("R4 no output after reset", m_valid, 0);

        // R2 R3 downscale both ways
        run_frame("R2 R3 downscale", 16, 8, 8, 4, 0, 0, 1, 1, 0);
        // R10 upscale both ways; line replay stalls the input
        run_frame("R10 upscale", 5, 3, 13, 7, 0, 0, 1, 1, 0);
        chk("R10 ready back after frame", m_ready, 1);
        // R4 independent ratios: shrink width, grow height
        run_frame("R4 mixed ratios", 20, 2, 7, 9, 0, 0, 1, 1, 0);
        run_frame("R4 single pixel source", 1, 1, 4, 3, 0, 0, 1, 1, 0);
        run_frame("R2 widest sizes", 64, 2, 128, 1, 0, 0, 1, 1, 0);

        // R5 mid-frame write does not alter frame, reads back at once
        run_frame("R5 sampled at start", 10, 4, 5, 3, 0, 9, 1, 1, 0);
        rd(3'd0, s); chk("R5 R1 new out_w read back", s, 9);

        // R7 illegal sizes and format
        run_frame("R7 in_w too large", 65, 1, 8, 2, 0, 0, 1, 1, 1);
        expect_err("R7 in_w");
        wr(3'd4, 0);
        rd(3'd4, s); chk("R8 writing 0 keeps flag", (s >> 1) & 1, 1);
        run_frame("R9 legal frame dropped while flagged", 4, 2, 4, 2, 0, 0, 1, 1, 1);
        clear_err();
        run_frame("R7 out_w zero", 4, 2, 0, 2, 0, 0, 1, 1, 1);
        expect_err("R7 out_w zero");
        clear_err();
        run_frame("R7 out_w too large", 4, 2, 129, 2, 0, 0, 1, 1, 1);
        expect_err("R7 out_w large");
        clear_err();
        run_frame("R7 out_h zero", 4, 2, 4, 0, 0, 0, 1, 1, 1);
        expect_err("R7 out_h zero");
        clear_err();
        run_frame("R7 chroma code", 4, 2, 4, 2, 2, 0, 1, 1, 1);
        expect_err("R7 chroma");
        clear_err();
        run_frame("R8 works after clear", 6, 3, 3, 5, 0, 0, 1, 1, 0);

        // R2 R3 random sizes
        for (int t = 0; t < 8; t++) begin
            int iw, ih, ow, oh;
            iw = 1 + int'($urandom % 64);
            ih = 1 + int'($urandom % 6);
            ow = 1 + int'($urandom % 128);
            oh = 1 + int'($urandom % 10);
            run_frame("R2 R3 random", iw, ih, ow, oh, 0, 0, 1, 1, 0);
        end

        // R6 bypass instance: output registers keep their reset values
        sel = 1'b1;
        @(negedge clk);
        got_q.delete();
        wr(3'd2, 6); wr(3'd3, 3);
        send_frame(6, 3, 0, 0);
        wait_idle("R6");
        @(negedge clk);
        chk("R6 bypass beat count", got_q.size(), 18);
        if (got_q.size() == 18) begin
            int mm;
            mm = 0;
            for (int k = 0; k < 18; k++)
                if (got_q[k][15:0] !== {8'(k / 6), 8'(k % 6)}) mm++;
            chk("R6 bypass pixels unchanged", mm, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule